// File: doc/BRIEF.md
# Flag-Preserving ALU with Skip Tests

A purely combinational arithmetic and logic unit for a small 16-bit accumulator-style processor. It combines a memory operand with a working-register operand under a 4-bit opcode and produces a result word, the next carry and zero flags, and a request to skip the next instruction. The flags themselves live outside the block. The caller feeds the stored carry and zero back in, and registers whatever comes out.

Each opcode has its own rule for which flags it writes and which it passes through. The shifts and the add and subtract update both flags. The bitwise operations and the zero test update only the zero flag. The two skip tests and the no-op codes leave both flags untouched. On subtract, carry means that no borrow occurred. The skip output is raised only by the two test opcodes, which look at whether the memory operand is zero.

Top module: `skip_alu`

## Requirements
- R1: Opcode 0 (shift left) gives the memory operand shifted left by one with 0 entering bit 0. Carry takes the old bit 15, and zero is set when the result is all zeros.
- R2: Opcode 1 (shift right) gives the memory operand shifted right by one with 0 entering bit 15. Carry takes the old bit 0, and zero is set when the result is all zeros.
- R3: Opcode 2 (add) gives memory plus working register modulo 2^16. Carry is the unsigned carry out of bit 15, and zero is set when the result is all zeros.
- R4: Opcode 3 (subtract) gives memory minus working register modulo 2^16. Carry is 1 when the unsigned memory operand is at least the working register (no borrow), and 0 otherwise. Zero is set when the result is all zeros.
- R5: Opcodes 4, 5 and 6 give the bitwise AND, OR and XOR of the two operands. Zero is set from the result and carry passes through unchanged.
- R6: Opcode 7 (zero test) passes the memory operand to the result, sets zero from it, and passes carry through unchanged.
- R7: Opcode 8 raises skip when the memory operand is nonzero, and opcode 9 raises skip when it is zero. Both pass carry and zero through unchanged and output the working register as the result.
- R8: Opcodes A through F are no-ops. The result is the working register, skip is 0, and both flags pass through unchanged.
- R9: Skip is 0 for every opcode other than 8 and 9, whatever the operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mem_opnd | input | 16 | Memory operand; source for shifts, zero test and skip tests |
| wreg_opnd | input | 16 | Working-register operand |
| carry_in | input | 1 | Stored carry flag |
| zero_in | input | 1 | Stored zero flag |
| opcode | input | 4 | Operation select |
| result | output | 16 | Result word |
| carry_out | output | 1 | Next carry flag |
| zero_out | output | 1 | Next zero flag |
| skip | output | 1 | Request to skip the next instruction |

## Verification
The embedded assertions check, on every evaluation, the rules that hold whatever the operand values are: skip stays low outside the two test opcodes, the flags pass through where an opcode must preserve them, the no-op codes return the working register, and the zero flag agrees with the result whenever an opcode writes it. Only the bench scenarios can show the arithmetic itself. These scenarios cover the shifted-out bit landing in carry, the carry out of an add, the no-borrow sense of subtract at the signed extremes, and the polarity of each skip test. A registered-flag scenario also shows that a flag set by one operation survives the operations that follow.

// File: rtl/skip_alu.sv
module skip_alu #(
  parameter int W = 16
) (
  input  logic [W-1:0] mem_opnd,
  input  logic [W-1:0] wreg_opnd,
  input  logic         carry_in,
  input  logic         zero_in,
  input  logic [3:0]   opcode,
  output logic [W-1:0] result,
  output logic         carry_out,
  output logic         zero_out,
  output logic         skip
);

  localparam logic [3:0] OP_SHL  = 4'h0;
  localparam logic [3:0] OP_SHR  = 4'h1;
  localparam logic [3:0] OP_ADD  = 4'h2;
  localparam logic [3:0] OP_SUB  = 4'h3;
  localparam logic [3:0] OP_AND  = 4'h4;
  localparam logic [3:0] OP_OR   = 4'h5;
  localparam logic [3:0] OP_XOR  = 4'h6;
  localparam logic [3:0] OP_ZTST = 4'h7;
  localparam logic [3:0] OP_SKNZ = 4'h8;
  localparam logic [3:0] OP_SKZ  = 4'h9;

  logic [W:0] sum_x, dif_x;
  logic       mem_is_zero, writes_zero;

  assign sum_x       = {1'b0, mem_opnd} + {1'b0, wreg_opnd};
  assign dif_x       = {1'b0, mem_opnd} - {1'b0, wreg_opnd};
  assign mem_is_zero = (mem_opnd == '0);
  assign writes_zero = (opcode <= OP_ZTST);

  always_comb begin
    result    = wreg_opnd;
    carry_out = carry_in;
    skip      = 1'b0;
    case (opcode)
      OP_SHL: begin
        result    = {mem_opnd[W-2:0], 1'b0};
        carry_out = mem_opnd[W-1];
      end
      OP_SHR: begin
        result    = {1'b0, mem_opnd[W-1:1]};
        carry_out = mem_opnd[0];
      end
      OP_ADD: begin
        result    = sum_x[W-1:0];
        carry_out = sum_x[W];
      end
      OP_SUB: begin
        result    = dif_x[W-1:0];
        carry_out = ~dif_x[W];
      end
      OP_AND:  result = mem_opnd & wreg_opnd;
      OP_OR:   result = mem_opnd | wreg_opnd;
      OP_XOR:  result = mem_opnd ^ wreg_opnd;
      OP_ZTST: result = mem_opnd;
      OP_SKNZ: skip   = ~mem_is_zero;
      OP_SKZ:  skip   = mem_is_zero;
      default: ;
    endcase
    zero_out = writes_zero ? (result == '0) : zero_in;

    if (!$isunknown({mem_opnd, wreg_opnd, carry_in, zero_in, opcode})) begin
      if (opcode != OP_SKNZ && opcode != OP_SKZ)
        a_r9_skip_only_tests: assert (!skip)
          else $error("skip raised by opcode %h", opcode);
      if (opcode == OP_SKNZ || opcode == OP_SKZ)
        a_r7_tests_keep_flags: assert (carry_out == carry_in && zero_out == zero_in
                                       && skip == (mem_opnd != '0) ^ (opcode == OP_SKZ))
          else $error("skip test disturbed flags or polarity");
      if (opcode >= OP_AND && opcode <= OP_ZTST)
        a_r5_carry_preserved: assert (carry_out == carry_in)
          else $error("carry changed by opcode %h", opcode);
      if (opcode > OP_SKZ)
        a_r8_nop_passthrough: assert (result == wreg_opnd && carry_out == carry_in
                                      && zero_out == zero_in)
          else $error("no-op altered state");
      if (opcode == OP_ZTST)
        a_r6_ztest_passes_mem: assert (result == mem_opnd && zero_out == mem_is_zero)
          else $error("zero test mismatch");
      if (opcode == OP_ADD)
        a_r3_add_carry: assert (carry_out == (result < mem_opnd))
          else $error("add carry inconsistent with wraparound");
    end
  end

endmodule

// File: tb/skip_alu_test.sv
module skip_alu_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_opnd, wreg_opnd;
  logic        c_set, z_set, chain;
  logic        c_q, z_q;
  logic [3:0]  opcode;
  logic [15:0] result;
  logic        carry_out, zero_out, skip;
  logic        carry_in, zero_in;
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  assign carry_in = chain ? c_q : c_set;
  assign zero_in  = chain ? z_q : z_set;

  always_ff @(posedge clk)
    if (!rst_n) begin
      c_q <= 1'b0;
      z_q <= 1'b0;
    end else if (chain) begin
      c_q <= carry_out;
      z_q <= zero_out;
    end

  skip_alu uut (
    .mem_opnd(mem_opnd), .wreg_opnd(wreg_opnd), .carry_in(carry_in),
    .zero_in(zero_in), .opcode(opcode), .result(result),
    .carry_out(carry_out), .zero_out(zero_out), .skip(skip)
  );

  task automatic chk(string req, string what, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic run(logic [3:0] op, logic [15:0] m, logic [15:0] w, logic ci, logic zi);
    @(negedge clk);
    opcode = op; mem_opnd = m; wreg_opnd = w; c_set = ci; z_set = zi;
    #1;
  endtask

  task automatic expect_all(string req, logic [15:0] r, logic c, logic z, logic s);
    chk(req, "result", result, r);
    chk(req, "carry", {15'b0, carry_out}, {15'b0, c});
    chk(req, "zero", {15'b0, zero_out}, {15'b0, z});
    chk(req, "skip", {15'b0, skip}, {15'b0, s});
  endtask

  task automatic t_reset;
    chain = 1'b1;
    @(negedge clk);
    opcode = 4'hF; mem_opnd = 16'h1234; wreg_opnd = 16'hBEEF;
    #1;
    expect_all("R8 reset", 16'hBEEF, 1'b0, 1'b0, 1'b0);
    chain = 1'b0;
  endtask

  task automatic t_shl;
    run(4'h0, 16'hAA55, 16'h0, 1'b0, 1'b0); expect_all("R1", 16'h54AA, 1'b1, 1'b0, 1'b0);
    run(4'h0, 16'h8000, 16'h0, 1'b0, 1'b0); expect_all("R1", 16'h0000, 1'b1, 1'b1, 1'b0);
    run(4'h0, 16'hFFFC, 16'h0, 1'b0, 1'b1); expect_all("R1", 16'hFFF8, 1'b1, 1'b0, 1'b0);
    run(4'h0, 16'h1234, 16'h0, 1'b1, 1'b1); expect_all("R1", 16'h2468, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_shr;
    run(4'h1, 16'hAA55, 16'h0, 1'b0, 1'b0); expect_all("R2", 16'h552A, 1'b1, 1'b0, 1'b0);
    run(4'h1, 16'h0001, 16'h0, 1'b0, 1'b0); expect_all("R2", 16'h0000, 1'b1, 1'b1, 1'b0);
    run(4'h1, 16'h8002, 16'h0, 1'b1, 1'b1); expect_all("R2", 16'h4001, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_add;
    run(4'h2, 16'h0001, 16'hFFFF, 1'b0, 1'b0); expect_all("R3", 16'h0000, 1'b1, 1'b1, 1'b0);
    run(4'h2, 16'h1234, 16'h1111, 1'b1, 1'b1); expect_all("R3", 16'h2345, 1'b0, 1'b0, 1'b0);
    run(4'h2, 16'h8000, 16'h8001, 1'b0, 1'b0); expect_all("R3", 16'h0001, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_sub;
    run(4'h3, 16'h0001, 16'h0001, 1'b0, 1'b0); expect_all("R4", 16'h0000, 1'b1, 1'b1, 1'b0);
    run(4'h3, 16'h0001, 16'h0002, 1'b1, 1'b1); expect_all("R4", 16'hFFFF, 1'b0, 1'b0, 1'b0);
    run(4'h3, 16'h8001, 16'h8001, 1'b0, 1'b0); expect_all("R4", 16'h0000, 1'b1, 1'b1, 1'b0);
    run(4'h3, 16'h7FFF, 16'h8001, 1'b1, 1'b0); expect_all("R4", 16'hFFFE, 1'b0, 1'b0, 1'b0);
    run(4'h3, 16'hFFFF, 16'h0002, 1'b0, 1'b1); expect_all("R4", 16'hFFFD, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_logic;
    run(4'h4, 16'hAA55, 16'h55AA, 1'b1, 1'b0); expect_all("R5 and", 16'h0000, 1'b1, 1'b1, 1'b0);
    run(4'h4, 16'hAA55, 16'hFFFF, 1'b0, 1'b1); expect_all("R5 and", 16'hAA55, 1'b0, 1'b0, 1'b0);
    run(4'h5, 16'hAA55, 16'h55AA, 1'b1, 1'b1); expect_all("R5 or", 16'hFFFF, 1'b1, 1'b0, 1'b0);
    run(4'h5, 16'h0000, 16'h0000, 1'b0, 1'b0); expect_all("R5 or", 16'h0000, 1'b0, 1'b1, 1'b0);
    run(4'h6, 16'hAA55, 16'hAA55, 1'b1, 1'b0); expect_all("R5 xor", 16'h0000, 1'b1, 1'b1, 1'b0);
    run(4'h6, 16'hAA55, 16'h55AA, 1'b0, 1'b1); expect_all("R5 xor", 16'hFFFF, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_ztest;
    run(4'h7, 16'h0000, 16'hC0DE, 1'b1, 1'b0); expect_all("R6", 16'h0000, 1'b1, 1'b1, 1'b0);
    run(4'h7, 16'h1234, 16'hC0DE, 1'b0, 1'b1); expect_all("R6", 16'h1234, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_skip;
    run(4'h8, 16'h0002, 16'h0BAD, 1'b1, 1'b0); expect_all("R7 op8", 16'h0BAD, 1'b1, 1'b0, 1'b1);
    run(4'h8, 16'h0000, 16'h0BAD, 1'b0, 1'b1); expect_all("R7 op8", 16'h0BAD, 1'b0, 1'b1, 1'b0);
    run(4'h9, 16'h0000, 16'h0BAD, 1'b1, 1'b1); expect_all("R7 op9", 16'h0BAD, 1'b1, 1'b1, 1'b1);
    run(4'h9, 16'h0005, 16'h0BAD, 1'b0, 1'b0); expect_all("R7 op9", 16'h0BAD, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_nop;
    for (int op = 10; op < 16; op++) begin
      run(op[3:0], 16'h0000, 16'hC0DE, op[0], ~op[0]);
      expect_all("R8", 16'hC0DE, op[0], ~op[0], 1'b0);
    end
  endtask

  task automatic t_noskip;
    for (int op = 0; op < 8; op++) begin
      run(op[3:0], 16'h0000, 16'h0000, 1'b1, 1'b1);
      chk("R9", "skip", {15'b0, skip}, 16'h0);
    end
  endtask

  task automatic t_chain;
    @(negedge clk);
    chain = 1'b1;
    opcode = 4'h2; mem_opnd = 16'h0001; wreg_opnd = 16'hFFFF;
    @(negedge clk);
    opcode = 4'h4; mem_opnd = 16'hAA55; wreg_opnd = 16'hAA55;
    #1;
    expect_all("R5 chained", 16'hAA55, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    opcode = 4'h9; mem_opnd = 16'h0000;
    #1;
    expect_all("R7 chained", 16'hAA55, 1'b1, 1'b0, 1'b1);
    chain = 1'b0;
  endtask

  initial begin
    chain = 1'b0; c_set = 1'b0; z_set = 1'b0;
    opcode = 4'hF; mem_opnd = '0; wreg_opnd = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_shl();
    t_shr();
    t_add();
    t_sub();
    t_logic();
    t_ztest();
    t_skip();
    t_nop();
    t_noskip();
    t_chain();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule